// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel data buses, called A and B, and moves data in either direction between them. Each direction has its own capture register, its own output enable and its own source select. When the select is low, the value driven onto the far bus is the live value of the near bus. When the select is high, the far bus gets the value held in that direction's register. Either register can be loaded from its near bus on any cycle, whatever the enables and selects are set to.

Each bus is modelled as a resolved value and not as an electrical net. One source is the block's own driver and the other is an external agent with its own enable. A bus that nobody drives keeps its last resolved value through a keeper register. If both directions drive in live mode and no external agent is active, the two drivers form a loop, and each bus keeps the value it last carried. All state sits in one clock domain. The two register clocks of a discrete transceiver are represented here by two independent capture strobes, one per direction.

Top module: `xcvr_regbus`

## Requirements
- R1: When `cap_ab` is high at a rising edge of `clk`, the A-to-B register loads the resolved A bus value, whatever the levels of `oe_ab`, `oe_ba_n`, `sel_ab` and `sel_ba`. When `cap_ab` is low, the register keeps its value.
- R2: When `cap_ba` is high at a rising edge of `clk`, the B-to-A register loads the resolved B bus value, under the same conditions as R1. When `cap_ba` is low, the register keeps its value.
- R3: `oe_ab` is active high and makes the block drive the B bus (`b_drv`=1). `oe_ba_n` is active low and makes the block drive the A bus (`a_drv`=1). With `oe_ab`=0 and `oe_ba_n`=1 the block drives neither bus.
- R4: A driven bus carries the live value of the opposite bus when its select is 0, and the stored register of that direction when its select is 1. `sel_ab` governs the B bus and `sel_ba` governs the A bus.
- R5: A bus driven by neither the block nor its external agent keeps the value it resolved to in the previous cycle.
- R6: With both directions enabled, both selects at 0 and no external agent active, each bus keeps its last value for as long as that configuration lasts.
- R7: If the B bus is driven live from the A bus and both strobes are high in the same cycle, both registers load the A value. The mirror case with the A bus driven live from B loads the B value into both registers.
- R8: With both directions enabled and both selects at 1, the A bus shows the B-to-A register and the B bus shows the A-to-B register in the same cycle.
- R9: With a select at 1, strobes given in successive cycles load both registers in order. A `cap_ab` followed by `cap_ba` while B is sourced from the stored A value leaves the newly captured A value in both registers.
- R10: When the external agent and the block drive the same bus together, that bus's clash output (`a_clash` or `b_clash`) is 1 and the bus resolves to the external data.
- R11: A synchronous active-high `rst` clears both registers and both bus keepers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and keepers |
| rst | input | 1 | Synchronous active-high reset |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| oe_ab | input | 1 | Active-high enable for driving the B bus |
| oe_ba_n | input | 1 | Active-low enable for driving the A bus |
| sel_ab | input | 1 | B bus source: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | A bus source: 0 live B, 1 stored B-to-A register |
| a_ext_en | input | 1 | External agent drives the A bus |
| a_ext_data | input | W | External agent data for the A bus |
| b_ext_en | input | 1 | External agent drives the B bus |
| b_ext_data | input | W | External agent data for the B bus |
| a_bus | output | W | Resolved A bus value |
| b_bus | output | W | Resolved B bus value |
| a_drv | output | 1 | The block is driving the A bus |
| b_drv | output | 1 | The block is driving the B bus |
| a_clash | output | 1 | The block and the external agent both drive A |
| b_clash | output | 1 | The block and the external agent both drive B |

## Verification
The assertions take one timing rule as given: while either select is high, `cap_ab` and `cap_ba` are never high in the same cycle. This block defines no result for simultaneous captures through a stored path. The stimulus raises both strobes together only while both selects are low. It also sets every input once per cycle, just after the falling edge, so each resolved bus value is stable for a full cycle before the next capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Origin of the value a bus resolves to in the current cycle.
    typedef enum logic [2:0] {
        SRC_HOLD,        // nobody drives: keeper value
        SRC_EXT,         // external agent
        SRC_STORED,      // block drives from its own register
        SRC_FAR_EXT,     // block drives live, far bus from its agent
        SRC_FAR_HOLD,    // block drives live, far bus floating
        SRC_FAR_STORED,  // block drives live, far bus from far register
        SRC_LOOP         // both directions live: feedback holds the value
    } src_e;

    // Control view of one bus side.
    typedef struct packed {
        logic ext_en;    // external agent active
        logic drv;       // block output enabled onto this bus
        logic sel;       // 1: stored register, 0: live far bus
    } ctl_t;

    // Decide where a bus gets its value, given its own controls (nc) and the
    // controls of the opposite bus (fc). External drive wins a clash.
    function automatic src_e pick_source(ctl_t nc, ctl_t fc);
        src_e s;
        if (nc.ext_en)        s = SRC_EXT;
        else if (!nc.drv)     s = SRC_HOLD;
        else if (nc.sel)      s = SRC_STORED;
        else if (fc.ext_en)   s = SRC_FAR_EXT;
        else if (!fc.drv)     s = SRC_FAR_HOLD;
        else if (fc.sel)      s = SRC_FAR_STORED;
        else                  s = SRC_LOOP;
        return s;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/xcvr_side.sv
module xcvr_side
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  ctl_t         nc,
    input  ctl_t         fc,
    input  logic [W-1:0] ext_data,
    input  logic [W-1:0] stored,
    input  logic [W-1:0] hold,
    input  logic [W-1:0] far_ext_data,
    input  logic [W-1:0] far_stored,
    input  logic [W-1:0] far_hold,
    output logic [W-1:0] bus_val,
    output logic         clash
);

    src_e src;

    always_comb begin
        src = pick_source(nc, fc);
        unique case (src)
            SRC_EXT:        bus_val = ext_data;
            SRC_STORED:     bus_val = stored;
            SRC_FAR_EXT:    bus_val = far_ext_data;
            SRC_FAR_HOLD:   bus_val = far_hold;
            SRC_FAR_STORED: bus_val = far_stored;
            default:        bus_val = hold;   // SRC_HOLD and SRC_LOOP
        endcase
    end

    assign clash = nc.ext_en & nc.drv;

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         a_ext_en,
    input  logic [W-1:0] a_ext_data,
    input  logic         b_ext_en,
    input  logic [W-1:0] b_ext_data,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] b_bus,
    output logic         a_drv,
    output logic         b_drv,
    output logic         a_clash,
    output logic         b_clash
);

    ctl_t         ctl_a, ctl_b;
    logic [W-1:0] stored_ab, stored_ba;
    logic [W-1:0] hold_a, hold_b;

    assign ctl_a = '{ext_en: a_ext_en, drv: ~oe_ba_n, sel: sel_ba};
    assign ctl_b = '{ext_en: b_ext_en, drv: oe_ab,    sel: sel_ab};
    assign a_drv = ctl_a.drv;
    assign b_drv = ctl_b.drv;

    // Direction registers
    xcvr_store #(.W(W)) reg_ab_i (
        .clk(clk), .rst(rst), .load(cap_ab), .d(a_bus), .q(stored_ab)
    );
    xcvr_store #(.W(W)) reg_ba_i (
        .clk(clk), .rst(rst), .load(cap_ba), .d(b_bus), .q(stored_ba)
    );

    // Bus keepers: always track the resolved value
    xcvr_store #(.W(W)) keep_a_i (
        .clk(clk), .rst(rst), .load(1'b1), .d(a_bus), .q(hold_a)
    );
    xcvr_store #(.W(W)) keep_b_i (
        .clk(clk), .rst(rst), .load(1'b1), .d(b_bus), .q(hold_b)
    );

    // Bus resolution, one per side
    xcvr_side #(.W(W)) side_a_i (
        .nc(ctl_a), .fc(ctl_b),
        .ext_data(a_ext_data), .stored(stored_ba), .hold(hold_a),
        .far_ext_data(b_ext_data), .far_stored(stored_ab), .far_hold(hold_b),
        .bus_val(a_bus), .clash(a_clash)
    );
    xcvr_side #(.W(W)) side_b_i (
        .nc(ctl_b), .fc(ctl_a),
        .ext_data(b_ext_data), .stored(stored_ab), .hold(hold_b),
        .far_ext_data(a_ext_data), .far_stored(stored_ba), .far_hold(hold_a),
        .bus_val(b_bus), .clash(b_clash)
    );

endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cap_ab,
    input logic         cap_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         a_ext_en,
    input logic [W-1:0] a_ext_data,
    input logic         b_ext_en,
    input logic [W-1:0] b_ext_data,
    input logic [W-1:0] a_bus,
    input logic [W-1:0] b_bus,
    input logic         a_clash,
    input logic         b_clash,
    input logic [W-1:0] stored_ab,
    input logic [W-1:0] stored_ba
);

    logic quiet, loop_cfg;
    assign quiet    = !oe_ab && oe_ba_n && !a_ext_en && !b_ext_en;
    assign loop_cfg = oe_ab && !sel_ab && !oe_ba_n && !sel_ba && !a_ext_en && !b_ext_en;

    AST_CAP_AB: assert property (@(posedge clk) disable iff (rst)
        cap_ab |=> stored_ab == $past(a_bus)); // R1
    AST_KEEP_AB: assert property (@(posedge clk) disable iff (rst)
        !cap_ab |=> $stable(stored_ab)); // R1
    AST_CAP_BA: assert property (@(posedge clk) disable iff (rst)
        cap_ba |=> stored_ba == $past(b_bus)); // R2
    AST_KEEP_BA: assert property (@(posedge clk) disable iff (rst)
        !cap_ba |=> $stable(stored_ba)); // R2
    AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (rst)
        (oe_ab && !sel_ab && !b_ext_en && a_ext_en) |-> b_bus == a_ext_data); // R4
    AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (rst)
        (!oe_ba_n && !sel_ba && !a_ext_en && b_ext_en) |-> a_bus == b_ext_data); // R4
    AST_STORED_TO_B: assert property (@(posedge clk) disable iff (rst)
        (oe_ab && sel_ab && !b_ext_en) |-> b_bus == stored_ab); // R4
    AST_STORED_TO_A: assert property (@(posedge clk) disable iff (rst)
        (!oe_ba_n && sel_ba && !a_ext_en) |-> a_bus == stored_ba); // R4
    AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (quiet && $past(quiet)) |-> (a_bus == $past(a_bus) && b_bus == $past(b_bus))); // R5
    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loop_cfg && $past(loop_cfg)) |-> (a_bus == $past(a_bus) && b_bus == $past(b_bus))); // R6
    AST_CROSS: assert property (@(posedge clk) disable iff (rst)
        (oe_ab && sel_ab && !oe_ba_n && sel_ba && !a_ext_en && !b_ext_en)
        |-> (a_bus == stored_ba && b_bus == stored_ab)); // R8
    AST_STAGGER: assert property (@(posedge clk) disable iff (rst)
        (sel_ab || sel_ba) |-> !(cap_ab && cap_ba)); // R9
    AST_CLASH_A: assert property (@(posedge clk) disable iff (rst)
        (a_ext_en && !oe_ba_n) |-> (a_clash && a_bus == a_ext_data)); // R10
    AST_CLASH_B: assert property (@(posedge clk) disable iff (rst)
        (b_ext_en && oe_ab) |-> (b_clash && b_bus == b_ext_data)); // R10

endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_ext_en(a_ext_en), .a_ext_data(a_ext_data),
    .b_ext_en(b_ext_en), .b_ext_data(b_ext_data),
    .a_bus(a_bus), .b_bus(b_bus), .a_clash(a_clash), .b_clash(b_clash),
    .stored_ab(stored_ab), .stored_ba(stored_ba)
);

// File: tb/xcvr_regbus_tb_top.sv
`timescale 1ns/1ps
module xcvr_regbus_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         cap_ab, cap_ba, oe_ab, oe_ba_n, sel_ab, sel_ba;
    logic         a_ext_en, b_ext_en;
    logic [W-1:0] a_ext_data, b_ext_data;
    logic [W-1:0] a_bus, b_bus;
    logic         a_drv, b_drv, a_clash, b_clash;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Bench-side state from the requirements
    logic [W-1:0] m_ab, m_ba, m_ha, m_hb;

    always #2.5 clk = ~clk;   // 200 MHz

    xcvr_regbus #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_ext_en(a_ext_en), .a_ext_data(a_ext_data),
        .b_ext_en(b_ext_en), .b_ext_data(b_ext_data),
        .a_bus(a_bus), .b_bus(b_bus), .a_drv(a_drv), .b_drv(b_drv),
        .a_clash(a_clash), .b_clash(b_clash)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected bus value per R3/R4/R5/R6/R10
    function automatic logic [W-1:0] bus_exp(
        input bit n_ext, input logic [W-1:0] n_dat, input bit n_drv, input bit n_sel,
        input logic [W-1:0] n_reg, input logic [W-1:0] n_hold,
        input bit f_ext, input logic [W-1:0] f_dat, input bit f_drv, input bit f_sel,
        input logic [W-1:0] f_reg, input logic [W-1:0] f_hold);
        if (n_ext)  return n_dat;   // R10: external wins
        if (!n_drv) return n_hold;  // R5
        if (n_sel)  return n_reg;   // R4 stored
        if (f_ext)  return f_dat;   // R4 live
        if (!f_drv) return f_hold;
        if (f_sel)  return f_reg;
        return n_hold;              // R6 loop
    endfunction

    // Check current outputs, then advance one clock and update the bench state.
    task automatic step(input string req, input bit chk);
        logic [W-1:0] ea, eb;
        #1;
        ea = bus_exp(a_ext_en, a_ext_data, !oe_ba_n, sel_ba, m_ba, m_ha,
                     b_ext_en, b_ext_data, oe_ab, sel_ab, m_ab, m_hb);
        eb = bus_exp(b_ext_en, b_ext_data, oe_ab, sel_ab, m_ab, m_hb,
                     a_ext_en, a_ext_data, !oe_ba_n, sel_ba, m_ba, m_ha);
        if (chk) begin
            check(req, "a_bus", a_bus, ea);
            check(req, "b_bus", b_bus, eb);
            check("R3/R10", "flags {a_drv,b_drv,a_clash,b_clash}",
                  {4'b0, a_drv, b_drv, a_clash, b_clash},
                  {4'b0, !oe_ba_n, oe_ab, a_ext_en & !oe_ba_n, b_ext_en & oe_ab});
        end
        @(posedge clk);
        if (rst) begin
            m_ab = '0; m_ba = '0; m_ha = '0; m_hb = '0;
        end else begin
            if (cap_ab) m_ab = ea;
            if (cap_ba) m_ba = eb;
            m_ha = ea;
            m_hb = eb;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cap_ab = 0; cap_ba = 0; oe_ab = 0; oe_ba_n = 1; sel_ab = 0; sel_ba = 0;
        a_ext_en = 0; b_ext_en = 0;
    endtask

    initial begin
        rst = 1; idle(); a_ext_data = '0; b_ext_data = '0;
        m_ab = '0; m_ba = '0; m_ha = '0; m_hb = '0;
        @(negedge clk);
        step("R11", 0); step("R11", 0);
        rst = 0;
        #1;
        check("R11", "a_bus after reset", a_bus, 8'h00);
        check("R11", "b_bus after reset", b_bus, 8'h00);
        check("R3", "drv flags isolated", {6'b0, a_drv, b_drv}, 8'h00);
        step("R11", 1);

        // R1/R2: simultaneous capture while isolated, selects low
        a_ext_en = 1; a_ext_data = 8'h5A; b_ext_en = 1; b_ext_data = 8'hC3;
        cap_ab = 1; cap_ba = 1;
        step("R1", 1);
        idle();
        oe_ab = 1; sel_ab = 1; oe_ba_n = 0; sel_ba = 1;
        #1;
        check("R1", "b_bus shows A-to-B register", b_bus, 8'h5A);
        check("R2", "a_bus shows B-to-A register", a_bus, 8'hC3);
        step("R8", 1);

        // R1: capture with B output enabled in stored mode
        oe_ba_n = 1; sel_ba = 0; a_ext_en = 1; a_ext_data = 8'h77; cap_ab = 1;
        step("R1", 1);
        cap_ab = 0; a_ext_en = 0;
        #1; check("R1", "b_bus after capture under stored drive", b_bus, 8'h77);
        step("R1", 1);

        // Sweep all enable/select combos, agents fill undriven sides
        for (int i = 0; i < 16; i++) begin
            idle();
            oe_ab = i[0]; oe_ba_n = i[1]; sel_ab = i[2]; sel_ba = i[3];
            a_ext_en = oe_ba_n; a_ext_data = 8'(i * 37 + 5);
            b_ext_en = !oe_ab;  b_ext_data = 8'(~(i * 19));
            step("R4", 1);
            a_ext_en = 0; b_ext_en = 0;
            step("R5", 1);
        end
        // Sweep again with both agents always active (clash cases)
        for (int i = 0; i < 16; i++) begin
            idle();
            oe_ab = i[0]; oe_ba_n = i[1]; sel_ab = i[2]; sel_ba = i[3];
            a_ext_en = 1; a_ext_data = 8'(i * 11 + 1);
            b_ext_en = 1; b_ext_data = 8'(i * 53 + 2);
            step("R10", 1);
        end

        // R6: feedback hold
        idle();
        oe_ab = 1; a_ext_en = 1; a_ext_data = 8'h96;
        step("R4", 1);
        oe_ba_n = 0;
        step("R10", 1);
        a_ext_en = 0;
        for (int k = 0; k < 4; k++) begin
            #1;
            check("R6", "a_bus held in loop", a_bus, 8'h96);
            check("R6", "b_bus held in loop", b_bus, 8'h96);
            step("R6", 1);
        end

        // R7: live copy into both registers, A to both
        idle();
        oe_ab = 1; a_ext_en = 1; a_ext_data = 8'h3C; cap_ab = 1; cap_ba = 1;
        step("R7", 1);
        idle();
        oe_ab = 1; sel_ab = 1; oe_ba_n = 0; sel_ba = 1;
        #1;
        check("R7", "a_bus shows B-to-A copy", a_bus, 8'h3C);
        check("R7", "b_bus shows A-to-B copy", b_bus, 8'h3C);
        step("R8", 1);
        // mirror: B to both
        idle();
        oe_ba_n = 0; b_ext_en = 1; b_ext_data = 8'hE1; cap_ab = 1; cap_ba = 1;
        step("R7", 1);
        idle();
        oe_ab = 1; sel_ab = 1; oe_ba_n = 0; sel_ba = 1;
        #1;
        check("R7", "a_bus mirror copy", a_bus, 8'hE1);
        check("R7", "b_bus mirror copy", b_bus, 8'hE1);
        step("R8", 1);

        // R9: staggered capture through stored path
        idle();
        oe_ab = 1; sel_ab = 1; a_ext_en = 1; a_ext_data = 8'h11; cap_ab = 1;
        step("R9", 1);
        cap_ab = 0; cap_ba = 1;
        step("R9", 1);
        cap_ba = 0; a_ext_en = 0; oe_ba_n = 0; sel_ba = 1;
        #1;
        check("R9", "a_bus from B-to-A after stagger", a_bus, 8'h11);
        check("R9", "b_bus from A-to-B after stagger", b_bus, 8'h11);
        step("R9", 1);

        // R10: explicit clash on B
        idle();
        oe_ab = 1; sel_ab = 1; b_ext_en = 1; b_ext_data = 8'hAA;
        #1;
        check("R10", "b_clash", {7'b0, b_clash}, 8'h01);
        check("R10", "b_bus under clash", b_bus, 8'hAA);
        step("R10", 1);

        idle();
        step("R5", 1);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule